// File: doc/BRIEF.md
# Prioritized Serial-Link Interrupt Vector Register

This block sits between the link engine of a byte-oriented vehicle-network controller and the CPU. It gathers eight kinds of link events into sticky pending flags. It encodes the most urgent flag that is still pending as a level from 0 to 8. It presents that level as a byte that firmware can add straight to the base of a jump table whose entries are four bytes apart. An interrupt request goes out while any flag is pending and interrupts are enabled.

Clearing depends on the kind of event. Most flags clear when the CPU reads the vector. The receive-side data conditions clear only when a vector read is followed by a data-register read. The transmit data condition clears when a vector read is followed by a data-register write, or when the end-of-data control bit is set. An invalid symbol places the link in a hold state, which lasts until an end-of-frame is received. While either loopback bit is set, the block ignores events that come from the bus.

Top module: `slink_irq_vector`

## Requirements
- R1: After a synchronous reset, `vec_out` is 0x00, `irq_req` is 0 and `link_hold` is 0.
- R2: `vec_out` equals the current level times four. The level sits in bits 5..2, and bits 1..0 and 7..6 are zero. A single pending end-of-frame gives 0x04.
- R3: The levels from lowest to highest priority are: 1 end-of-frame, 2 in-frame-response byte, 3 receive data full, 4 transmit data empty, 5 arbitration lost, 6 CRC error, 7 invalid symbol, 8 wakeup. `evt_pulse` bit i belongs to level i+1. The vector reports the highest pending level, and lower levels stay pending.
- R4: A flag set by an event pulse stays set until its own clearing rule fires.
- R5: A `vec_rd` pulse clears the reported flag when that flag is level 1, 5, 6, 7 or 8. The change is seen after the clock edge.
- R6: A `vec_rd` pulse alone does not clear level 2, 3 or 4.
- R7: Level 2 or 3 clears on a `data_rd` pulse that follows a `vec_rd` pulse that reported that level. A `data_rd` pulse with no such preceding read has no effect.
- R8: Level 4 clears on a `data_wr` pulse that follows a `vec_rd` pulse that reported level 4. It also clears in any cycle in which `tx_end_data` is high.
- R9: A `vec_rd` pulse that reports a different level cancels a pending two-step clear. A later data access then leaves the earlier flag set.
- R10: An invalid-symbol event raises `link_hold`. Only a later end-of-frame event lowers it. If both events arrive in the same cycle, `link_hold` is set.
- R11: While `loop_a` or `loop_b` is high, every event except transmit data empty (level 4) is ignored.
- R12: `irq_req` is high exactly when the level is nonzero and `irq_en` is high.
- R13: An event that arrives in the same cycle as the clear of its own flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 8 | Event pulses from the link engine; bit i is level i+1 |
| vec_rd | input | 1 | CPU read strobe of the vector register |
| data_rd | input | 1 | CPU read strobe of the data register |
| data_wr | input | 1 | CPU write strobe of the data register |
| tx_end_data | input | 1 | Transmit end-of-data control bit |
| loop_a | input | 1 | First loopback mode bit |
| loop_b | input | 1 | Second loopback mode bit |
| irq_en | input | 1 | Interrupt enable |
| vec_out | output | 8 | State-vector byte (level times four) |
| irq_req | output | 1 | Interrupt request |
| link_hold | output | 1 | Link must neither receive nor transmit |

## Verification
The vector is tested with these patterns:
- Single events, which confirm the encoding of each level.
- Pairs and a burst of all eight events, drained by repeated vector reads, which confirm the priority order and that lower flags stay pending.
- Two-step sequences, both complete and broken. Broken ones are a data access with no preceding vector read, or a vector read that reports a different level in between. These separate the read-clear flags from the data flags.
- Event traffic in loopback, a set and a clear in the same cycle, and the interrupt enable held low. These separate gating, set priority and request masking from the encoding itself.

// File: rtl/slink_irq_pkg.sv
package slink_irq_pkg;
  localparam int NUM_LVL   = 8;
  localparam int LVL_W     = 4;
  localparam int VEC_SHIFT = 2;
  localparam int VEC_W     = 8;

  localparam logic [LVL_W-1:0] LV_NONE  = 4'd0;
  localparam logic [LVL_W-1:0] LV_EOF   = 4'd1;
  localparam logic [LVL_W-1:0] LV_IFR   = 4'd2;
  localparam logic [LVL_W-1:0] LV_RXF   = 4'd3;
  localparam logic [LVL_W-1:0] LV_TXE   = 4'd4;
  localparam logic [LVL_W-1:0] LV_ARB   = 4'd5;
  localparam logic [LVL_W-1:0] LV_CRC   = 4'd6;
  localparam logic [LVL_W-1:0] LV_SYM   = 4'd7;
  localparam logic [LVL_W-1:0] LV_WAKE  = 4'd8;

  // one-hot flag position of a level; level 0 maps to no bit
  function automatic logic [NUM_LVL-1:0] lvl_onehot(input logic [LVL_W-1:0] lvl);
    logic [NUM_LVL-1:0] oh;
    oh = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (LVL_W'(i + 1) == lvl) oh[i] = 1'b1;
    return oh;
  endfunction

  // highest pending level; ascending scan, last hit wins
  function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL-1:0] pend);
    logic [LVL_W-1:0] lv;
    lv = LV_NONE;
    for (int i = 0; i < NUM_LVL; i++)
      if (pend[i]) lv = LVL_W'(i + 1);
    return lv;
  endfunction

  function automatic logic [VEC_W-1:0] lvl_to_vec(input logic [LVL_W-1:0] lvl);
    logic [VEC_W-1:0] v;
    v = '0;
    v[VEC_SHIFT +: LVL_W] = lvl;
    return v;
  endfunction

  function automatic logic clears_on_vec_read(input logic [LVL_W-1:0] lvl);
    return (lvl == LV_EOF) || (lvl >= LV_ARB && lvl <= LV_WAKE);
  endfunction

  function automatic logic is_rx_data(input logic [LVL_W-1:0] lvl);
    return (lvl == LV_IFR) || (lvl == LV_RXF);
  endfunction

  function automatic logic is_data_lvl(input logic [LVL_W-1:0] lvl);
    return is_rx_data(lvl) || (lvl == LV_TXE);
  endfunction
endpackage

// File: rtl/slink_event_gate.sv
module slink_event_gate
  import slink_irq_pkg::*;
#(
  parameter int N = NUM_LVL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_pulse,
  input  logic         loop_a,
  input  logic         loop_b,
  output logic [N-1:0] set_mask,
  output logic         link_hold
);
  localparam logic [N-1:0] LOCAL_KEEP = N'(lvl_onehot(LV_TXE));

  logic detached;
  assign detached = loop_a | loop_b;
  assign set_mask = detached ? (evt_pulse & LOCAL_KEEP) : evt_pulse;

  logic sym_hit, eof_hit;
  assign sym_hit = |(set_mask & N'(lvl_onehot(LV_SYM)));
  assign eof_hit = |(set_mask & N'(lvl_onehot(LV_EOF)));

  always_ff @(posedge clk) begin
    if (rst)          link_hold <= 1'b0;
    else if (sym_hit) link_hold <= 1'b1;
    else if (eof_hit) link_hold <= 1'b0;
  end
endmodule

// File: rtl/slink_flag_bank.sv
module slink_flag_bank
  import slink_irq_pkg::*;
#(
  parameter int N = NUM_LVL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              pend[g] <= 1'b0;
      else if (set_mask[g]) pend[g] <= 1'b1;
      else if (clr_mask[g]) pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/slink_clear_ctl.sv
module slink_clear_ctl
  import slink_irq_pkg::*;
#(
  parameter int N = NUM_LVL,
  parameter int W = LVL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur_lvl,
  input  logic         vec_rd,
  input  logic         data_rd,
  input  logic         data_wr,
  input  logic         tx_end_data,
  output logic [N-1:0] clr_mask,
  output logic [W-1:0] armed
);
  logic rx_done, tx_done;
  assign rx_done = data_rd && is_rx_data(armed);
  assign tx_done = data_wr && (armed == LV_TXE);

  always_comb begin
    clr_mask = '0;
    if (vec_rd && clears_on_vec_read(cur_lvl)) clr_mask |= N'(lvl_onehot(cur_lvl));
    if (rx_done)     clr_mask |= N'(lvl_onehot(armed));
    if (tx_done)     clr_mask |= N'(lvl_onehot(LV_TXE));
    if (tx_end_data) clr_mask |= N'(lvl_onehot(LV_TXE));
  end

  always_ff @(posedge clk) begin
    if (rst)                    armed <= LV_NONE;
    else if (vec_rd)            armed <= is_data_lvl(cur_lvl) ? cur_lvl : LV_NONE;
    else if (rx_done | tx_done) armed <= LV_NONE;
  end
endmodule

// File: rtl/slink_irq_vector.sv
module slink_irq_vector
  import slink_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_LVL-1:0] evt_pulse,
  input  logic             vec_rd,
  input  logic             data_rd,
  input  logic             data_wr,
  input  logic             tx_end_data,
  input  logic             loop_a,
  input  logic             loop_b,
  input  logic             irq_en,
  output logic [VEC_W-1:0] vec_out,
  output logic             irq_req,
  output logic             link_hold
);
  logic [NUM_LVL-1:0] set_mask;
  logic [NUM_LVL-1:0] clr_mask;
  logic [NUM_LVL-1:0] pend;
  logic [LVL_W-1:0]   cur_lvl;
  logic [LVL_W-1:0]   armed;

  slink_event_gate #(.N(NUM_LVL)) gate_i (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse),
    .loop_a(loop_a), .loop_b(loop_b),
    .set_mask(set_mask), .link_hold(link_hold)
  );

  slink_flag_bank #(.N(NUM_LVL)) bank_i (
    .clk(clk), .rst(rst), .set_mask(set_mask),
    .clr_mask(clr_mask), .pend(pend)
  );

  assign cur_lvl = top_level(pend);

  slink_clear_ctl #(.N(NUM_LVL), .W(LVL_W)) clr_i (
    .clk(clk), .rst(rst), .cur_lvl(cur_lvl),
    .vec_rd(vec_rd), .data_rd(data_rd), .data_wr(data_wr),
    .tx_end_data(tx_end_data), .clr_mask(clr_mask), .armed(armed)
  );

  assign vec_out = lvl_to_vec(cur_lvl);
  assign irq_req = irq_en && (cur_lvl != LV_NONE);
endmodule

// File: rtl/slink_irq_vector_chk.sv
module slink_irq_vector_chk
  import slink_irq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               loop_a,
  input logic               loop_b,
  input logic               vec_rd,
  input logic               data_rd,
  input logic               irq_en,
  input logic [VEC_W-1:0]   vec_out,
  input logic               irq_req,
  input logic               link_hold,
  input logic [NUM_LVL-1:0] pend,
  input logic [NUM_LVL-1:0] set_mask,
  input logic [NUM_LVL-1:0] clr_mask,
  input logic [LVL_W-1:0]   cur_lvl
);
  AST_IRQ_FOLLOWS_VEC: assert property (@(posedge clk) disable iff (rst)
    irq_req == ((vec_out != '0) && irq_en)); // R12

  AST_WAKE_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    pend[NUM_LVL-1] |-> (vec_out == 8'h20)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend & $past(pend & ~clr_mask)) == $past(pend & ~clr_mask))); // R4

  AST_READ_CLEARS_WAKE: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && cur_lvl == LV_WAKE && !set_mask[NUM_LVL-1]) |=> !pend[NUM_LVL-1]); // R5

  AST_RXFULL_SURVIVES_VEC: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !data_rd && cur_lvl == LV_RXF) |=> pend[2]); // R6

  AST_HOLD_RISES: assert property (@(posedge clk) disable iff (rst)
    set_mask[6] |=> link_hold); // R10

  AST_HOLD_DROPS_ON_EOF: assert property (@(posedge clk) disable iff (rst)
    (set_mask[0] && !set_mask[6]) |=> !link_hold); // R10

  AST_LOOP_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    ((loop_a || loop_b) && !pend[NUM_LVL-1]) |=> !pend[NUM_LVL-1]); // R11
endmodule

bind slink_irq_vector slink_irq_vector_chk chk_i (
  .clk(clk), .rst(rst), .loop_a(loop_a), .loop_b(loop_b),
  .vec_rd(vec_rd), .data_rd(data_rd), .irq_en(irq_en),
  .vec_out(vec_out), .irq_req(irq_req), .link_hold(link_hold),
  .pend(pend), .set_mask(set_mask), .clr_mask(clr_mask), .cur_lvl(cur_lvl)
);

// File: tb/slink_irq_vector_tb_top.sv
module slink_irq_vector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt_pulse = '0;
  logic vec_rd = 0, data_rd = 0, data_wr = 0, tx_end_data = 0;
  logic loop_a = 0, loop_b = 0, irq_en = 0;
  logic [7:0] vec_out;
  logic irq_req, link_hold;

  always #10 clk = ~clk;  // 50 MHz

  slink_irq_vector dut_i (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .vec_rd(vec_rd),
    .data_rd(data_rd), .data_wr(data_wr), .tx_end_data(tx_end_data),
    .loop_a(loop_a), .loop_b(loop_b), .irq_en(irq_en),
    .vec_out(vec_out), .irq_req(irq_req), .link_hold(link_hold)
  );

  typedef struct {
    logic [7:0] vec;
    logic       irq;
    logic       hold;
    string      tag;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state: m_p[1..8] pending, arm level, hold
  bit m_p[1:8];
  int m_arm;
  bit m_hold;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int m_top();
    for (int l = 8; l >= 1; l--) if (m_p[l]) return l;
    return 0;
  endfunction

  task automatic step(input logic [7:0] ev, input bit vr, input bit dr, input bit dw,
                      input bit ted, input bit lp, input bit en, input string tag);
    int top, narm;
    bit clr[1:8];
    bit st[1:8];
    exp_t e;
    @(negedge clk);
    evt_pulse = ev; vec_rd = vr; data_rd = dr; data_wr = dw;
    tx_end_data = ted; loop_a = lp; loop_b = 1'b0; irq_en = en;
    top = m_top();
    for (int l = 1; l <= 8; l++) clr[l] = 0;
    narm = m_arm;
    if (vr) begin
      if (top == 1 || top >= 5) clr[top] = 1;
      narm = (top >= 2 && top <= 4) ? top : 0;
    end
    if (dr && (m_arm == 2 || m_arm == 3)) begin clr[m_arm] = 1; if (!vr) narm = 0; end
    if (dw && m_arm == 4) begin clr[4] = 1; if (!vr) narm = 0; end
    if (ted) clr[4] = 1;
    for (int l = 1; l <= 8; l++) st[l] = ev[l-1] && (l == 4 || !lp);
    for (int l = 1; l <= 8; l++) m_p[l] = st[l] || (m_p[l] && !clr[l]);
    m_arm = narm;
    if (st[7]) m_hold = 1; else if (st[1]) m_hold = 0;
    e.vec = 8'(m_top() * 4);
    e.irq = (m_top() != 0) && en;
    e.hold = m_hold;
    e.tag = tag;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(8'h00, 0, 0, 0, 0, 0, 1, tag);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        e = q.pop_front();
        n_cmp++;
        if (vec_out !== e.vec || irq_req !== e.irq || link_hold !== e.hold) begin
          n_bad++;
          $display("FAIL %s: vec=%h irq=%b hold=%b expected vec=%h irq=%b hold=%b",
                   e.tag, vec_out, irq_req, link_hold, e.vec, e.irq, e.hold);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    exp_t e;
    for (int l = 1; l <= 8; l++) m_p[l] = 0;
    m_arm = 0; m_hold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    irq_en = 1;
    // R1: outputs while still in reset with irq_en high
    #1;
    n_cmp++;
    if (vec_out !== 8'h00 || irq_req !== 1'b0 || link_hold !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: vec=%h irq=%b hold=%b expected vec=00 irq=0 hold=0",
               vec_out, irq_req, link_hold);
    end
    rst = 0;
    idle("R1 idle after reset");
    // R2 single EOF
    step(8'h01, 0, 0, 0, 0, 0, 1, "R2 eof encodes 0x04");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R5 vec read clears eof");
    // R3 priority
    step(8'h24, 0, 0, 0, 0, 0, 1, "R3 crc over rxfull");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R3 lower rxfull remains");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R6 vec read keeps rxfull");
    step(8'h00, 0, 1, 0, 0, 0, 1, "R7 data read completes rxfull");
    // R7 data read without arm
    step(8'h02, 0, 0, 0, 0, 0, 1, "R4 ifr set");
    step(8'h00, 0, 1, 0, 0, 0, 1, "R7 unarmed data read ignored");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R6 vec read keeps ifr");
    step(8'h00, 0, 1, 0, 0, 0, 1, "R7 data read clears ifr");
    // R8 tx empty both ways
    step(8'h08, 0, 0, 0, 0, 0, 1, "R8 txempty set");
    step(8'h00, 0, 0, 1, 0, 0, 1, "R8 unarmed write ignored");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R6 vec read keeps txempty");
    step(8'h00, 0, 0, 1, 0, 0, 1, "R8 write clears txempty");
    step(8'h08, 0, 0, 0, 0, 0, 1, "R8 txempty set again");
    step(8'h00, 0, 0, 0, 1, 0, 1, "R8 end-of-data clears txempty");
    // R9 arm cancelled
    step(8'h04, 0, 0, 0, 0, 0, 1, "R9 rxfull set");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R9 arm on rxfull");
    step(8'h10, 0, 0, 0, 0, 0, 1, "R9 arb lost arrives");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R9 read reports arb lost");
    step(8'h00, 0, 1, 0, 0, 0, 1, "R9 stale data read ignored");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R9 rearm rxfull");
    step(8'h00, 0, 1, 0, 0, 0, 1, "R9 rxfull cleared");
    // R12 enable masking
    step(8'h80, 0, 0, 0, 0, 0, 0, "R12 wake with enable low");
    step(8'h00, 0, 0, 0, 0, 0, 1, "R12 wake with enable high");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R5 vec read clears wake");
    // R10 hold
    step(8'h40, 0, 0, 0, 0, 0, 1, "R10 bad symbol holds link");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R10 hold survives flag clear");
    step(8'h01, 0, 0, 0, 0, 0, 1, "R10 eof releases hold");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R5 clear eof");
    // R11 loopback
    step(8'hFF, 0, 0, 0, 0, 1, 1, "R11 loopback keeps only txempty");
    step(8'h00, 0, 0, 0, 1, 0, 1, "R11 txempty removed");
    // R13 set wins
    step(8'h01, 0, 0, 0, 0, 0, 1, "R13 eof set");
    step(8'h01, 1, 0, 0, 0, 0, 1, "R13 set beats clear");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R13 clear after");
    // R3 full burst drain
    step(8'hFF, 0, 0, 0, 0, 0, 1, "R3 burst top is wake");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R3 drain to symbol");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R3 drain to crc");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R3 drain to arb");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R3 drain to txempty");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R6 txempty held");
    step(8'h00, 0, 0, 1, 0, 0, 1, "R8 write drains txempty");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R6 rxfull held");
    step(8'h00, 0, 1, 0, 0, 0, 1, "R7 read drains rxfull");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R6 ifr held");
    step(8'h00, 0, 1, 0, 0, 0, 1, "R7 read drains ifr");
    step(8'h00, 1, 0, 0, 0, 0, 1, "R5 drain eof");
    idle("R1 quiet end");
    repeat (2) @(posedge clk);
    #6;
    finish_run();
  end
endmodule